// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a clocked request stream to an external 256K x 16 asynchronous static RAM. A requester offers one access at a time: an 18-bit word address, a read or write flag, 16 bits of write data and a two-bit byte enable. The controller then runs the memory's control pins (chip select, output enable, write strobe and two byte selects, all active low) through a fixed sequence of clock cycles. Each read completes with a one-cycle response that carries the sampled word.

The memory has no clock, so its access time is covered by a wait-state parameter. This parameter equals the access time divided by the clock period, rounded up. Reads hold address and controls for exactly that many cycles and sample at the end of the last one. Writes frame the strobe with one setup cycle and one hold cycle. The data bus is split into a driven value, a per-byte-lane drive enable and an input value. A lane is driven only while the write strobe and that lane's select are both low. The output enable never overlaps a write.

Back-pressure: `req_ready` is high only while the controller is idle and does not depend on `req_valid`. A request transfers on a clock edge where both are high. The requester must hold its fields stable while `req_valid` is high and `req_ready` is low. Read responses cannot be stalled: `rsp_valid` is a single-cycle pulse.

Top module: `sram_ctrl`

## Requirements
- R1: A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is high only when the controller is idle, so it is low in the cycle after acceptance and stays low until the access sequence ends.
- R2: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with an unchanged `mem_addr` for exactly WAIT_CYC consecutive cycles. The data bus is sampled at the clock edge that ends the last of those cycles.
- R3: `rsp_valid` is high for exactly one cycle, the cycle right after the last read cycle, and `rsp_rdata` holds the sampled word. Any lane whose enable bit is 0 reads as zero.
- R4: Byte enable bit 0 (value 1 = used) drives `mem_lb_n` low and governs data bits 7:0. Bit 1 drives `mem_ub_n` low and governs bits 15:8. The selects stay at that value for the whole access.
- R5: A write is one setup cycle (chip selected, write strobe high, bus released), then WAIT_CYC cycles with `mem_we_n`=0, then one hold cycle. In the hold cycle the strobe is high, the chip stays selected, address and selects are unchanged and the bus is released. The controller then returns to idle.
- R6: A data lane drive enable (`mem_dq_oe[i]`) is high only while `mem_we_n` is low and that lane's select is low. The lane then carries the lane's write data. `mem_oe_n` stays high for the whole write.
- R7: While `mem_ce_n` is high, `mem_oe_n` and `mem_we_n` are high and no lane is driven.
- R8: `mem_oe_n` low never coincides with `mem_we_n` low or any lane being driven. From a read to a following write, the bus stays released for at least one cycle.
- R9: During and right after reset: `req_ready`=1, `mem_ce_n`=1, `rsp_valid`=0, no lane driven.
- R10: A request with byte enable 00 still runs its full sequence with both selects high. A write of that kind changes no memory word, and a read of that kind returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_dq_o | output | 16 | Value driven onto the data bus |
| mem_dq_oe | output | 2 | Per-lane drive enable, bit 0 = bits 7:0 |
| mem_dq_i | input | 16 | Value read from the data bus |

## Verification
The bench builds the controller with WAIT_CYC set to 3, rather than the default of 2. With three cycles, a sample taken one cycle early or a strobe one cycle short can be told apart from the correct length. The bench's memory model returns a junk pattern until output enable has been low for WAIT_CYC half-cycle checkpoints, so an early sample returns wrong data. Writes and reads mix all four byte-enable patterns, including 00. They run back to back so that read-to-write turnaround and the address 3FFFF are covered.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } seq_state_t;
endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       go_wr,
  output seq_state_t st,
  output logic       rd_last
);
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (go) begin
          st  <= go_wr ? ST_WR_SETUP : ST_RD;
          cnt <= LOAD;
        end
        ST_RD: begin
          if (cnt == '0) st <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_WR_SETUP: begin
          st  <= ST_WR_PULSE;
          cnt <= LOAD;
        end
        ST_WR_PULSE: begin
          if (cnt == '0) st <= ST_WR_HOLD;
          else cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_last = (st == ST_RD) && (cnt == '0);

  // R5: the strobe phase is always entered from the setup phase
  assert_setup_before_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_WR_PULSE) |-> $past(st == ST_WR_SETUP));
  // R5: the hold phase always follows the strobe phase
  assert_hold_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR_HOLD) |-> $past(st == ST_WR_PULSE));
endmodule

// File: rtl/sram_lane.sv
module sram_lane
  import sram_ctrl_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        st,
  input  logic              en,
  input  logic              sample,
  input  logic [LANE_W-1:0] wdata,
  input  logic [LANE_W-1:0] dq_i,
  output logic              sel_n,
  output logic [LANE_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [LANE_W-1:0] rdata
);
  assign sel_n = !(en && (st != ST_IDLE));
  assign dq_oe = en && (st == ST_WR_PULSE);
  assign dq_o  = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (sample) rdata <= en ? dq_i : '0;
  end

  // R3: a lane not enabled always returns zero
  assert_masked_lane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !en) |=> (rdata == '0));
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W/8-1:0] mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int LANES = DATA_W / 8;
  localparam int RUN_W = $clog2(WAIT_CYC + 2);

  seq_state_t        st;
  logic              rd_last;
  logic              go;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  sel_n;

  assign req_ready = (st == ST_IDLE);
  assign go        = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= rd_last;
      if (go) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
    end
  end

  sram_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_wr(req_write),
    .st(st), .rd_last(rd_last)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane #(.LANE_W(8)) u_lane (
      .clk(clk), .rst_n(rst_n), .st(st), .en(be_q[g]), .sample(rd_last),
      .wdata(wdata_q[8*g +: 8]), .dq_i(mem_dq_i[8*g +: 8]),
      .sel_n(sel_n[g]), .dq_o(mem_dq_o[8*g +: 8]), .dq_oe(mem_dq_oe[g]),
      .rdata(rsp_rdata[8*g +: 8])
    );
  end

  assign mem_addr = addr_q;
  assign mem_ce_n = (st == ST_IDLE);
  assign mem_oe_n = (st != ST_RD);
  assign mem_we_n = (st != ST_WR_PULSE);
  assign mem_lb_n = sel_n[0];
  assign mem_ub_n = sel_n[LANES-1];

  // checker counters for the strobe lengths
  logic [RUN_W-1:0] rd_run, wr_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      rd_run <= mem_oe_n ? '0 : rd_run + 1'b1;
      wr_run <= mem_we_n ? '0 : wr_run + 1'b1;
    end
  end

  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_read_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rd_run == RUN_W'(WAIT_CYC)));
  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_write_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wr_run == RUN_W'(WAIT_CYC)));
  assert_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && $stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));
  assert_lane_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != '0) |-> (!mem_we_n && ((mem_dq_oe & sel_n) == '0)));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_oe_n && mem_we_n && (mem_dq_oe == '0)));
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && (mem_dq_oe == '0)));
  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe != '0) |-> $past(mem_oe_n));
endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [17:0] mem_addr;
  logic [1:0]  mem_dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl #(.WAIT_CYC(W)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model
  logic [15:0] mem [int];
  logic [15:0] ref_mem [int];
  int rd_cnt = 0;
  function automatic logic [15:0] rd_word(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction
  function automatic logic [15:0] ref_word(input logic [17:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
  endfunction
  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_cnt >= W) begin
      mem_dq_i[7:0]  = mem_lb_n ? 8'hA5 : rd_word(mem_addr)[7:0];
      mem_dq_i[15:8] = mem_ub_n ? 8'h5A : rd_word(mem_addr)[15:8];
    end else mem_dq_i = 16'hBAD0;
  end
  always @(negedge clk) rd_cnt <= (!mem_ce_n && !mem_oe_n && mem_we_n) ? rd_cnt + 1 : 0;
  always @(posedge clk) if (!mem_ce_n && !mem_we_n) begin
    logic [15:0] w;
    w = rd_word(mem_addr);
    if (mem_dq_oe[0] && !mem_lb_n) w[7:0]  = mem_dq_o[7:0];
    if (mem_dq_oe[1] && !mem_ub_n) w[15:8] = mem_dq_o[15:8];
    mem[int'(mem_addr)] = w;
  end

  // scoreboard
  logic [15:0] exp_q [$];
  logic [1:0]  cur_be = 2'b00;

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    cur_be = be;
    if (wr) begin
      logic [15:0] w;
      w = ref_word(a);
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      ref_mem[int'(a)] = w;
    end else begin
      exp_q.push_back(ref_word(a) & {{8{be[1]}}, {8{be[0]}}});
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 ready low after accept", req_ready, 0);
  endtask

  // monitor
  int rd_len = 0, last_rd_len = 0, wr_len = 0;
  logic [17:0] rd_a0, p_addr;
  bit addr_moved = 0;
  logic p_we_n = 1, p_ce_n = 1, p_lb = 1, p_ub = 1;
  logic [1:0] p_oe = 0;
  always @(negedge clk) if (rst_n) begin
    if (mem_ce_n) chk(mem_oe_n && mem_we_n && mem_dq_oe == 0, "R7 idle pins", {mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1100);
    else chk({mem_ub_n, mem_lb_n} == ~cur_be, "R4 selects", {mem_ub_n, mem_lb_n}, ~cur_be);
    if (!mem_oe_n) chk(mem_we_n && mem_dq_oe == 0, "R8 no overlap", {mem_we_n, mem_dq_oe}, 3'b100);
    for (int i = 0; i < 2; i++)
      if (mem_dq_oe[i]) chk(!mem_we_n && !(i == 0 ? mem_lb_n : mem_ub_n), "R6 lane drive", i, 0);
    if (!mem_ce_n && !mem_oe_n) begin
      if (rd_len == 0) begin rd_a0 = mem_addr; addr_moved = 0; end
      else if (mem_addr != rd_a0) addr_moved = 1;
      rd_len++;
    end else if (rd_len != 0) begin
      last_rd_len = rd_len; rd_len = 0;
    end
    if (rsp_valid) begin
      chk(last_rd_len == W && !addr_moved, "R2 read length/address", last_rd_len, W);
      if (exp_q.size() == 0) chk(0, "R3 unexpected response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R3 read data", rsp_rdata, e);
      end
    end
    if (!mem_we_n) begin
      chk(mem_oe_n, "R6 oe high in write", mem_oe_n, 1);
      if (p_we_n) chk(!p_ce_n && p_oe == 0 && p_addr == mem_addr, "R5 setup cycle", {p_ce_n, p_oe}, 0);
      wr_len++;
    end else if (wr_len != 0) begin
      chk(wr_len == W, "R5 strobe length", wr_len, W);
      chk(!mem_ce_n && mem_addr == p_addr && mem_lb_n == p_lb && mem_ub_n == p_ub && mem_dq_oe == 0,
          "R5 hold cycle", {mem_ce_n, mem_dq_oe}, 0);
      wr_len = 0;
    end
    p_we_n = mem_we_n; p_ce_n = mem_ce_n; p_oe = mem_dq_oe; p_addr = mem_addr;
    p_lb = mem_lb_n; p_ub = mem_ub_n;
  end

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || !req_ready) && t < 100) begin @(negedge clk); t++; end
    chk(exp_q.size() == 0, "R3 responses drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n && !rsp_valid && mem_dq_oe == 0, "R9 in reset",
        {req_ready, mem_ce_n, rsp_valid, mem_dq_oe}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !rsp_valid, "R9 after reset", {req_ready, mem_ce_n, rsp_valid}, 3'b110);
    issue(1, 18'h00000, 16'h1234, 2'b11);
    issue(0, 18'h00000, 16'h0000, 2'b11);
    issue(1, 18'h00010, 16'hAAAA, 2'b11);
    issue(1, 18'h00010, 16'hFF55, 2'b01);   // R4 lower lane only
    issue(1, 18'h00010, 16'h66FF, 2'b10);   // R4 upper lane only
    issue(0, 18'h00010, 16'h0000, 2'b11);
    issue(0, 18'h00010, 16'h0000, 2'b01);
    issue(0, 18'h00010, 16'h0000, 2'b10);
    issue(1, 18'h3FFFF, 16'hC0DE, 2'b11);
    issue(0, 18'h3FFFF, 16'h0000, 2'b11);   // read then write: R8 turnaround
    issue(1, 18'h3FFFF, 16'h9999, 2'b00);   // R10 masked write
    issue(0, 18'h3FFFF, 16'h0000, 2'b00);   // R10 masked read returns 0
    issue(0, 18'h3FFFF, 16'h0000, 2'b11);
    for (int k = 0; k < 8; k++) issue(1, 18'(k * 18'h1111), 16'(k * 16'h3C5), 2'(k));
    for (int k = 0; k < 8; k++) issue(0, 18'(k * 18'h1111), 16'h0, 2'b11);
    drain();
    chk(rd_word(18'h3FFFF) == 16'hC0DE, "R10 memory unchanged", rd_word(18'h3FFFF), 16'hC0DE);
    chk(rd_word(18'h00010) == 16'h6655, "R4 lane merge", rd_word(18'h00010), 16'h6655);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule